// File: doc/BRIEF.md
# P-224 Redundant Modular Adder-Subtractor

This block adds or subtracts two 224-bit residues modulo the prime p = 2^224 − 2^96 + 1. Operands and results live in the redundant range [0, 2^224). A result may therefore be at or above p, but it always fits in 224 bits. No comparison against p is ever made. Any weight at or above 2^224 is folded back into the low bits through the congruence 2^224 ≡ 2^96 − 1 (mod p).

The block works one 32-bit limb at a time, least significant limb first, and makes three passes over the seven limbs:
- The first pass forms a + b, or 2p + a − b for a subtraction. The bias of 2p keeps the value non-negative.
- The second pass adds the overflow count times (2^96 − 1).
- The third pass always runs a second fold of the same kind. Its constant is masked to zero when the second pass did not carry.

The cycle count is therefore the same for every operand value. A caller pulses `start` with the operands and the operation select. It then waits for the one-cycle `done` pulse and reads `result`, which holds until the next accepted start.

Top module: `p224_addsub`

## Requirements
- R1: With `sub`=0, the result equals s = a + b after s is replaced by s − 2^224 + 2^96 − 1 as long as s ≥ 2^224. The result is therefore congruent to a + b modulo p.
- R2: With `sub`=1, the result equals s = 2p + a − b reduced by the same repeated replacement. The result is therefore congruent to a − b modulo p.
- R3: The third pass never carries out of bit 223, so the result is always below 2^224 for any inputs below 2^224.
- R4: The overflow above bit 223 after the first pass is 0 or 1 for an addition, and 0, 1 or 2 for a subtraction.
- R5: The second pass carries out at most 1, and only when the first overflow was non-zero. When it does carry, the third pass folds that carry in.
- R6: The fold constant for an overflow k is k·(2^96 − 1), spread over limbs 0 to 3:
  - limb 0 is 2^32 − k;
  - limbs 1 and 2 are all ones;
  - limb 3 is k − 1;
  - every limb is zero when k = 0.
  The constant is built by masking, not by selecting among branches.
- R7: `done` rises exactly 21 clock cycles after the cycle in which `start` is accepted, for every operand value and operation.
- R8: A `start` pulse while `busy` is high is ignored. It does not alter the operation in flight and does not start a new one.
- R9: `done` is a one-cycle pulse. `result` stays unchanged from `done` until the next accepted `start`.
- R10: After reset, `busy` and `done` are low and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only while `busy` is low |
| sub | input | 1 | Operation select: 0 adds, 1 subtracts opb from opa |
| opa | input | 224 | First operand, below 2^224 |
| opb | input | 224 | Second operand, below 2^224 |
| busy | output | 1 | High while an operation is being processed |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | 224 | Redundant residue below 2^224 |

## Verification
The assertions watch every cycle for the following:
- the range of the first overflow for each operation;
- the bound on the second-pass carry and its dependence on a non-zero first overflow;
- the absence of any carry out of the final pass;
- the fixed 21-cycle latency;
- the freezing of captured operands while busy;
- the holding of the result while idle.

Only the bench scenarios can show that the folded value is exactly right and congruent modulo p. The scenarios cover:
- the edge operands 0, p − 1 and 2^224 − 1;
- an addition and a subtraction that each force the second fold;
- a subtraction with an overflow of two;
- a start pulse issued in the middle of an operation.

// File: rtl/p224_pkg.sv
package p224_pkg;
  localparam int LIMB_W    = 32;
  localparam int NUM_LIMBS = 7;
  localparam int FIELD_W   = LIMB_W * NUM_LIMBS;
  localparam int IDX_W     = $clog2(NUM_LIMBS);
  localparam int CARRY_W   = 3;
  localparam int OVF_W     = 2;
  localparam int PASSES    = 3;
  localparam int LATENCY   = PASSES * NUM_LIMBS;
  localparam int LAT_W     = $clog2(LATENCY + 1);

  typedef logic [LIMB_W-1:0] limb_t;
  typedef enum logic [1:0] {PH_SUM = 2'd0, PH_FOLD1 = 2'd1, PH_FOLD2 = 2'd2} phase_e;

  // Limb idx of ovf*(2^96-1), built with masks only (R6)
  function automatic limb_t fold_limb(input logic [OVF_W-1:0] ovf, input logic [IDX_W-1:0] idx);
    limb_t mask;
    limb_t ext;
    mask = {LIMB_W{|ovf}};
    ext  = limb_t'(ovf);
    case (idx)
      IDX_W'(0): fold_limb = limb_t'(0) - ext;
      IDX_W'(1): fold_limb = mask;
      IDX_W'(2): fold_limb = mask;
      IDX_W'(3): fold_limb = (ext - limb_t'(1)) & mask;
      default:   fold_limb = '0;
    endcase
  endfunction

  // Limb idx of 2p below bit 224; bit 224 of 2p is added to the overflow
  function automatic limb_t two_p_limb(input logic [IDX_W-1:0] idx);
    case (idx)
      IDX_W'(0): two_p_limb = limb_t'(2);
      IDX_W'(3): two_p_limb = {{(LIMB_W-1){1'b1}}, 1'b0};
      IDX_W'(4), IDX_W'(5), IDX_W'(6): two_p_limb = '1;
      default:   two_p_limb = '0;
    endcase
  endfunction
endpackage

// File: rtl/p224_limb_alu.sv
module p224_limb_alu
  import p224_pkg::*;
(
  input  limb_t                      x,
  input  limb_t                      y,
  input  limb_t                      z,
  input  logic signed [CARRY_W-1:0]  cin,
  output limb_t                      sum,
  output logic signed [CARRY_W-1:0]  cout
);
  localparam int ACC_W = LIMB_W + CARRY_W;
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc = $signed({{CARRY_W{1'b0}}, x}) + $signed({{CARRY_W{1'b0}}, y})
        - $signed({{CARRY_W{1'b0}}, z}) + $signed({{LIMB_W{cin[CARRY_W-1]}}, cin});
  end

  assign sum  = acc[LIMB_W-1:0];
  assign cout = acc[ACC_W-1:LIMB_W];
endmodule

// File: rtl/p224_fold_gen.sv
module p224_fold_gen
  import p224_pkg::*;
(
  input  logic [OVF_W-1:0] ovf,
  input  logic [IDX_W-1:0] idx,
  output limb_t            k
);
  assign k = fold_limb(ovf, idx);
endmodule

// File: rtl/p224_seq.sv
module p224_seq
  import p224_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic             first,
  output logic             last,
  output phase_e           phase,
  output logic [IDX_W-1:0] idx
);
  assign accept = start && !busy;
  assign first  = (idx == '0);
  assign last   = (idx == IDX_W'(NUM_LIMBS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      phase <= PH_SUM;
      idx   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        phase <= PH_SUM;
        idx   <= '0;
      end else if (busy) begin
        if (last) begin
          idx <= '0;
          if (phase == PH_FOLD2) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            phase <= phase_e'(phase + 2'd1);
          end
        end else begin
          idx <= idx + IDX_W'(1);
        end
      end
    end
  end

  // R9: done lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: rtl/p224_addsub.sv
module p224_addsub
  import p224_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               sub,
  input  logic [FIELD_W-1:0] opa,
  input  logic [FIELD_W-1:0] opb,
  output logic               busy,
  output logic               done,
  output logic [FIELD_W-1:0] result
);
  logic [FIELD_W-1:0]       opa_q, opb_q, work_q;
  logic                     sub_q;
  logic signed [CARRY_W-1:0] carry_q;
  logic [OVF_W-1:0]         ovf1_q, ovf2_q;
  logic [LAT_W-1:0]         lat_cnt;

  logic             accept, first, last;
  phase_e           phase;
  logic [IDX_W-1:0] idx;

  p224_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .accept(accept), .first(first), .last(last), .phase(phase), .idx(idx)
  );

  // Fold constant for the current fold pass
  logic [OVF_W-1:0] fold_ovf;
  limb_t            fold_k;
  assign fold_ovf = (phase == PH_FOLD1) ? ovf1_q : ovf2_q;

  p224_fold_gen u_fold (.ovf(fold_ovf), .idx(idx), .k(fold_k));

  // Operand selection for the limb ALU
  limb_t a_limb, b_limb, w_limb, alu_x, alu_y, alu_z, alu_sum;
  logic signed [CARRY_W-1:0] alu_cin, alu_cout;
  assign a_limb = opa_q[idx*LIMB_W +: LIMB_W];
  assign b_limb = opb_q[idx*LIMB_W +: LIMB_W];
  assign w_limb = work_q[idx*LIMB_W +: LIMB_W];

  always_comb begin
    if (phase == PH_SUM) begin
      alu_x = a_limb;
      alu_y = sub_q ? two_p_limb(idx) : b_limb;
      alu_z = sub_q ? b_limb : '0;
    end else begin
      alu_x = w_limb;
      alu_y = fold_k;
      alu_z = '0;
    end
  end
  assign alu_cin = first ? '0 : carry_q;

  p224_limb_alu u_alu (
    .x(alu_x), .y(alu_y), .z(alu_z), .cin(alu_cin), .sum(alu_sum), .cout(alu_cout)
  );

  // Named internal events for the assertions
  logic                end_sum, end_fold1, end_fold2;
  logic [CARRY_W-1:0]  alu_cout_u, sum_ovf;
  assign end_sum    = busy && (phase == PH_SUM)   && last;
  assign end_fold1  = busy && (phase == PH_FOLD1) && last;
  assign end_fold2  = busy && (phase == PH_FOLD2) && last;
  assign alu_cout_u = $unsigned(alu_cout);
  assign sum_ovf    = alu_cout_u + (sub_q ? CARRY_W'(1) : CARRY_W'(0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q   <= '0;
      opb_q   <= '0;
      work_q  <= '0;
      sub_q   <= 1'b0;
      carry_q <= '0;
      ovf1_q  <= '0;
      ovf2_q  <= '0;
      lat_cnt <= '0;
    end else if (accept) begin
      opa_q   <= opa;
      opb_q   <= opb;
      sub_q   <= sub;
      lat_cnt <= '0;
    end else if (busy) begin
      work_q[idx*LIMB_W +: LIMB_W] <= alu_sum;
      carry_q <= alu_cout;
      lat_cnt <= lat_cnt + LAT_W'(1);
      if (end_sum)   ovf1_q <= sum_ovf[OVF_W-1:0];
      if (end_fold1) ovf2_q <= alu_cout_u[OVF_W-1:0];
    end
  end

  assign result = work_q;

  // R4: first overflow range per operation
  a_r4_first_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    end_sum |-> (sum_ovf <= (sub_q ? CARRY_W'(2) : CARRY_W'(1))));
  // R5: second carry at most one, only after a non-zero first overflow
  a_r5_second_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    end_fold1 |-> ((alu_cout_u <= CARRY_W'(1)) && (alu_cout_u == '0 || ovf1_q != '0)));
  // R3: last pass never carries out of the field width
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    end_fold2 |-> (alu_cout_u == '0));
  // R7: fixed latency from accept to done
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LAT_W'(LATENCY)));
  // R8: start while busy leaves captured operands untouched
  a_r8_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(opa_q) && $stable(opb_q) && $stable(sub_q)));
  // R9: result holds while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

// File: tb/p224_addsub_test.sv
module p224_addsub_test;
  import p224_pkg::*;

  localparam logic [255:0] P    = (256'd1 << 224) - (256'd1 << 96) + 256'd1;
  localparam logic [255:0] TOP  = 256'd1 << 224;
  localparam logic [255:0] FOLD = (256'd1 << 96) - 256'd1;
  localparam logic [223:0] MAXV = {224{1'b1}};
  localparam int unsigned  LAT_OBS = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic sub_i = 1'b0;
  logic [223:0] opa_i = '0, opb_i = '0;
  logic busy, done;
  logic [223:0] result;

  always #2 clk = ~clk;

  p224_addsub uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub_i), .opa(opa_i), .opb(opb_i),
    .busy(busy), .done(done), .result(result)
  );

  int unsigned n_checks = 0, n_errors = 0, pos_cnt = 0;
  logic [223:0] last_exp = '0;

  typedef struct {
    logic [223:0] exp_val;
    logic [223:0] exp_mod;
    int unsigned  t0;
    logic         is_sub;
  } item_t;
  item_t sb[$];

  always @(posedge clk) pos_cnt <= pos_cnt + 1;

  function automatic logic [223:0] fold_ref(input logic [255:0] s);
    logic [255:0] v = s;
    while (v >= TOP) v = v - TOP + FOLD;
    return v[223:0];
  endfunction

  function automatic logic [255:0] mod_p(input logic [255:0] v);
    logic [255:0] r = v;
    while (r >= P) r = r - P;
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [223:0] a, input logic [223:0] b, input logic s);
    item_t it;
    logic [255:0] wa, wb, wide;
    while (busy) @(negedge clk);
    wa = {32'd0, a};
    wb = {32'd0, b};
    wide = s ? (2 * P + wa - wb) : (wa + wb);
    it.exp_val = fold_ref(wide);
    it.exp_mod = s ? 224'(mod_p(mod_p(wa) + P - mod_p(wb))) : 224'(mod_p(wa + wb));
    it.t0 = pos_cnt;
    it.is_sub = s;
    sb.push_back(it);
    last_exp = it.exp_val;
    opa_i = a; opb_i = b; sub_i = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Monitor: pop expected items as results appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 R9 unexpected done", 256'(result), 256'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(result == it.exp_val, it.is_sub ? "R2 sub folded value" : "R1 add folded value",
              256'(result), 256'(it.exp_val));
        check(224'(mod_p({32'd0, result})) == it.exp_mod,
              it.is_sub ? "R2 sub congruence" : "R1 add congruence",
              mod_p({32'd0, result}), 256'(it.exp_mod));
        check((pos_cnt - it.t0) == LAT_OBS, "R7 latency",
              256'(pos_cnt - it.t0), 256'(LAT_OBS));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", pos_cnt);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [223:0] pm1, ra, rb;
    pm1 = 224'(P - 256'd1);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 1'b0, "R10 busy", 256'(busy), 256'd0);
    check(done == 1'b0, "R10 done", 256'(done), 256'd0);
    check(result == '0, "R10 result", 256'(result), 256'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == '0, "R10 result after release", 256'(result), 256'd0);

    run_op('0, '0, 1'b0);                     // R1 zero
    run_op('0, '0, 1'b1);                     // R2 zero, result equals p
    run_op(pm1, pm1, 1'b0);                   // R1 p-1 operands
    run_op(MAXV, MAXV, 1'b0);                 // R5 R3 add forces second fold
    run_op(MAXV, 224'd1, 1'b0);               // R6 overflow 1 with zero low part
    run_op(MAXV, '0, 1'b1);                   // R4 R6 sub overflow of two
    run_op('0, MAXV, 1'b1);                   // R4 sub overflow of zero
    run_op(pm1, MAXV, 1'b1);                  // R2 edge
    run_op(MAXV, pm1, 1'b0);                  // R1 edge
    run_op(224'(256'd1 << 96), '0, 1'b1);     // R5 sub forces second fold
    run_op(224'(256'd1 << 96) + 224'd5, 224'd4, 1'b1); // R5 second fold, lower edge
    for (int i = 0; i < 12; i++) begin
      ra = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      run_op(ra, rb, 1'b0);                   // R1 random
      run_op(ra, rb, 1'b1);                   // R2 random
    end

    // R8: start pulse in mid-operation is ignored
    run_op(MAXV, 224'd77, 1'b0);
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R8 busy mid-operation", 256'(busy), 256'd1);
    opa_i = 224'd123; opb_i = 224'd456; sub_i = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;

    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", 256'(done), 256'd0);
    repeat (8) @(negedge clk);
    check(result == last_exp, "R9 result held", 256'(result), 256'(last_exp));
    check(busy == 1'b0, "R8 no extra operation", 256'(busy), 256'd0);
    repeat (30) @(negedge clk);
    check(sb.size() == 0, "R8 queue drained", 256'(sb.size()), 256'd0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule